// File: doc/BRIEF.md
# Bit-Slice Pattern Match Engine

This block looks for boolean patterns across a small group of pin inputs. The pins are asynchronous. They pass through a synchronizer. Eight bit slices then each pick one synchronized pin and test it against a 3-bit condition code. The conditions are a level, a latched (sticky) edge, a single-cycle edge event, always true, or never true.

Neighbouring slices are combined with AND into product terms. A term is closed by a slice whose endpoint flag is set. The last slice always closes a term, whether or not a flag is set for it. When a product term is true, the match bit of the slice that closes it goes high. The match bits are registered and are updated on every clock.

Software sets up the block through two write ports:
- **Selection register:** holds the pin chosen by each slice.
- **Condition register:** holds each slice's condition code and the endpoint flags.

Both registers can be read back. Writing the selection register, even with its current value, re-arms every sticky edge detector in the slices.

Top module: `pm_engine`

## Requirements
- R1: Synchronous reset loads every condition field with code 6 (never), clears all endpoint flags, clears the selection register and drives all match bits to 0.
- R2: In the selection register, slice n's 3-bit pin index sits at bits [8+3n +: 3], and bits 7:0 read back as 0. In the condition register, slice n's 3-bit code sits at bits [8+3n +: 3], and the endpoint flag of slice n (n = 0..6) is bit n. Bit 7 of the condition register reads back as 0. Registers keep their value when they are not written.
- R3: Code 4 is true while the selected pin is high. Code 5 is true while the selected pin is low. A pin change made before clock edge k shows on the match bit after edge k+2.
- R4: Code 0 is always true. Code 6 is never true.
- R5: Codes 1, 2 and 3 are sticky conditions. Once a rising edge (code 1), a falling edge (code 2) or either edge (code 3) is seen on the selected pin, the slice stays true from the detection cycle onward.
- R6: Any write to the selection register clears all sticky state. The match bit of a term that was held true only by sticky state is 0 two edges after the write edge.
- R7: Code 7 is true for exactly one cycle on each rising or falling edge of the selected pin.
- R8: A term is the AND of the consecutive slices that start just after the previous endpoint and run up to and including the endpoint slice. Its result appears only on the endpoint slice's match bit. Match bits of slices that are not endpoints stay 0.
- R9: Slice 7 always closes a term, even though it has no endpoint flag.
- R10: The match bits are registered. Under arbitrary pin activity and register writes, they follow R3 to R9 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| src_we | input | 1 | Selection register write strobe |
| src_wdata | input | SRC_W | Selection register write data |
| cfg_we | input | 1 | Condition register write strobe |
| cfg_wdata | input | CFG_W | Condition register write data (codes and endpoint flags) |
| src_q | output | SRC_W | Selection register readback |
| cfg_q | output | CFG_W | Condition register readback |
| match_o | output | NUM_SLICES | Registered per-slice match status |

## Verification
The assertions have three preconditions:
- Reset is applied at least once before any property is armed.
- The condition codes change only through a condition-register write, so a sticky bit can be raised only by a slice whose previous code was a sticky one.
- The selection register changes only on a write strobe.

The stimulus always begins with reset and drives every input on the falling clock edge. It changes registers only through single-cycle write pulses. Random data fills the whole register width, including the reserved bits, so the masking is exercised without breaking those preconditions.

// File: rtl/pm_pkg.sv
package pm_pkg;

  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    COND_ALWAYS   = 3'd0,
    COND_RISE_STK = 3'd1,
    COND_FALL_STK = 3'd2,
    COND_ANY_STK  = 3'd3,
    COND_HIGH     = 3'd4,
    COND_LOW      = 3'd5,
    COND_NEVER    = 3'd6,
    COND_EVENT    = 3'd7
  } pm_cond_e;

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
  parameter int NUM_PINS = 8,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pins_i,
  output logic [NUM_PINS-1:0] cur_o,
  output logic [NUM_PINS-1:0] prev_o
);

  logic [NUM_PINS-1:0] stg_q [STAGES];
  logic [NUM_PINS-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q[0] <= '0;
    end else begin
      stg_q[0] <= pins_i;
    end
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg_q[s] <= '0;
      else     stg_q[s] <= stg_q[s-1];
    end
  end

  // One more flop per pin keeps the previous synchronized value for edge detection.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= stg_q[STAGES-1];
  end

  assign cur_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/pm_slice.sv
module pm_slice import pm_pkg::*; #(
  parameter int NUM_PINS = 8,
  parameter int SEL_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [COND_W-1:0]   cond_i,
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  output logic                hit_o,
  output logic                sticky_o
);

  logic lvl, old, rise, fall, set, sticky_q;

  assign lvl  = cur_i[sel_i];
  assign old  = prev_i[sel_i];
  assign rise = lvl & ~old;
  assign fall = ~lvl & old;

  always_comb begin
    set   = 1'b0;
    hit_o = 1'b0;
    unique case (pm_cond_e'(cond_i))
      COND_ALWAYS:   hit_o = 1'b1;
      COND_RISE_STK: begin set = rise;        hit_o = sticky_q | rise;        end
      COND_FALL_STK: begin set = fall;        hit_o = sticky_q | fall;        end
      COND_ANY_STK:  begin set = rise | fall; hit_o = sticky_q | rise | fall; end
      COND_HIGH:     hit_o = lvl;
      COND_LOW:      hit_o = ~lvl;
      COND_NEVER:    hit_o = 1'b0;
      COND_EVENT:    hit_o = rise | fall;
      default:       hit_o = 1'b0;
    endcase
  end

  // A selection-register write wins over a same-cycle detection.
  always_ff @(posedge clk) begin
    if (rst || clr_i) sticky_q <= 1'b0;
    else if (set)     sticky_q <= 1'b1;
  end

  assign sticky_o = sticky_q;

endmodule

// File: rtl/pm_term_chain.sv
module pm_term_chain #(
  parameter int NUM_SLICES = 8
) (
  input  logic [NUM_SLICES-1:0] hit_i,
  input  logic [NUM_SLICES-1:0] endp_i,
  output logic [NUM_SLICES-1:0] term_o
);

  logic [NUM_SLICES-1:0] acc;

  assign acc[0] = hit_i[0];

  for (genvar i = 1; i < NUM_SLICES; i++) begin : g_link
    // A closed term upstream restarts the running AND at this slice.
    assign acc[i] = hit_i[i] & (endp_i[i-1] | acc[i-1]);
  end

  assign term_o = acc & endp_i;

endmodule

// File: rtl/pm_engine.sv
module pm_engine import pm_pkg::*; #(
  parameter int NUM_PINS    = 8,
  parameter int NUM_SLICES  = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_PINS),
  localparam int FIELD_BASE = NUM_SLICES,
  localparam int SRC_W      = FIELD_BASE + SEL_W * NUM_SLICES,
  localparam int CFG_W      = FIELD_BASE + COND_W * NUM_SLICES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PINS-1:0]   pins_i,
  input  logic                  src_we,
  input  logic [SRC_W-1:0]      src_wdata,
  input  logic                  cfg_we,
  input  logic [CFG_W-1:0]      cfg_wdata,
  output logic [SRC_W-1:0]      src_q,
  output logic [CFG_W-1:0]      cfg_q,
  output logic [NUM_SLICES-1:0] match_o
);

  localparam logic [SRC_W-1:0] SRC_MASK =
    {{(SEL_W*NUM_SLICES){1'b1}}, {FIELD_BASE{1'b0}}};
  localparam logic [CFG_W-1:0] CFG_MASK =
    {{(COND_W*NUM_SLICES){1'b1}}, 1'b0, {(NUM_SLICES-1){1'b1}}};

  function automatic logic [CFG_W-1:0] idle_cfg();
    logic [CFG_W-1:0] v;
    v = '0;
    for (int i = 0; i < NUM_SLICES; i++) begin
      v[FIELD_BASE + COND_W*i +: COND_W] = COND_NEVER;
    end
    return v;
  endfunction

  logic [SRC_W-1:0]      src_r;
  logic [CFG_W-1:0]      cfg_r;
  logic [NUM_PINS-1:0]   cur_w, prev_w;
  logic [NUM_SLICES-1:0] hit_w, sticky_w, endp_w, term_w, match_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_r <= '0;
      cfg_r <= idle_cfg();
    end else begin
      if (src_we) src_r <= src_wdata & SRC_MASK;
      if (cfg_we) cfg_r <= cfg_wdata & CFG_MASK;
    end
  end

  pm_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .pins_i (pins_i),
    .cur_o  (cur_w),
    .prev_o (prev_w)
  );

  for (genvar g = 0; g < NUM_SLICES; g++) begin : g_slice
    pm_slice #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) slice_i (
      .clk      (clk),
      .rst      (rst),
      .clr_i    (src_we),
      .sel_i    (src_r[FIELD_BASE + SEL_W*g +: SEL_W]),
      .cond_i   (cfg_r[FIELD_BASE + COND_W*g +: COND_W]),
      .cur_i    (cur_w),
      .prev_i   (prev_w),
      .hit_o    (hit_w[g]),
      .sticky_o (sticky_w[g])
    );
  end

  // The last slice always closes a term.
  assign endp_w = {1'b1, cfg_r[NUM_SLICES-2:0]};

  pm_term_chain #(.NUM_SLICES(NUM_SLICES)) chain_i (
    .hit_i  (hit_w),
    .endp_i (endp_w),
    .term_o (term_w)
  );

  always_ff @(posedge clk) begin
    if (rst) match_r <= '0;
    else     match_r <= term_w;
  end

  assign src_q   = src_r;
  assign cfg_q   = cfg_r;
  assign match_o = match_r;

endmodule

// File: rtl/pm_engine_chk.sv
module pm_engine_chk #(
  parameter int NUM_SLICES = 8,
  parameter int SRC_W      = 32,
  parameter int CFG_W      = 32
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  src_we,
  input logic [SRC_W-1:0]      src_q,
  input logic [CFG_W-1:0]      cfg_q,
  input logic [NUM_SLICES-1:0] match_o,
  input logic [NUM_SLICES-1:0] sticky
);

  logic armed = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    $past(rst) |-> (match_o == '0 && src_q == '0 && cfg_q[NUM_SLICES-2:0] == '0));

  // R2
  assert_src_hold_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    !src_we |=> $stable(src_q));

  // R8
  assert_non_endpoint_quiet_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    (match_o & ~{1'b1, $past(cfg_q[NUM_SLICES-2:0])}) == '0);

  // R6
  assert_clear_on_src_write_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    src_we |=> (sticky == '0));

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_cause
    // R5
    assert_sticky_cause_R5: assert property (@(posedge clk) disable iff (rst || !armed)
      $rose(sticky[i]) |->
        ($past(cfg_q[NUM_SLICES + 3*i +: 3]) inside {3'd1, 3'd2, 3'd3}));
  end

endmodule

bind pm_engine pm_engine_chk #(
  .NUM_SLICES (NUM_SLICES),
  .SRC_W      (SRC_W),
  .CFG_W      (CFG_W)
) chk_i (
  .clk     (clk),
  .rst     (rst),
  .src_we  (src_we),
  .src_q   (src_q),
  .cfg_q   (cfg_q),
  .match_o (match_o),
  .sticky  (sticky_w)
);

// File: tb/pm_engine_tb_top.sv
module pm_engine_tb_top;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  pins;
  logic        src_we, cfg_we;
  logic [31:0] src_wdata, cfg_wdata;
  logic [31:0] src_q, cfg_q;
  logic [7:0]  match_o;

  int n_chk  = 0;
  int n_fail = 0;
  string cur_tag = "R10";

  always #10 clk = ~clk;

  pm_engine dut_i (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (pins),
    .src_we    (src_we),
    .src_wdata (src_wdata),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .src_q     (src_q),
    .cfg_q     (cfg_q),
    .match_o   (match_o)
  );

  function automatic logic [31:0] rst_cfg();
    logic [31:0] v = '0;
    for (int i = 0; i < 8; i++) v[8 + 3*i +: 3] = 3'd6;
    return v;
  endfunction

  function automatic logic [31:0] mk_cfg(input logic [23:0] conds, input logic [6:0] ep);
    return {conds, 1'b0, ep};
  endfunction

  // Returns {sticky_set, slice_true} for one slice, per R3..R7.
  function automatic logic [1:0] slice_eval(input logic [2:0] c, input logic lv,
                                            input logic od, input logic st);
    logic r, f;
    r = lv & ~od;
    f = ~lv & od;
    case (c)
      3'd0: return {1'b0, 1'b1};
      3'd1: return {r, st | r};
      3'd2: return {f, st | f};
      3'd3: return {r | f, st | r | f};
      3'd4: return {1'b0, lv};
      3'd5: return {1'b0, ~lv};
      3'd6: return 2'b00;
      default: return {1'b0, r | f};
    endcase
  endfunction

  // Reference model
  logic [31:0] m_src, m_cfg;
  logic [7:0]  m_s1, m_s2, m_pv, m_st, m_match;

  always @(posedge clk) begin
    if (rst) begin
      m_src <= '0; m_cfg <= rst_cfg();
      m_s1 <= '0; m_s2 <= '0; m_pv <= '0; m_st <= '0; m_match <= '0;
    end else begin
      logic [7:0] set_v, out_v;
      logic run;
      run = 1'b1;
      for (int i = 0; i < 8; i++) begin
        logic [1:0] e;
        logic [2:0] sel;
        sel = m_src[8 + 3*i +: 3];
        e = slice_eval(m_cfg[8 + 3*i +: 3], m_s2[sel], m_pv[sel], m_st[i]);
        set_v[i] = e[1];
        run = run & e[0];
        if (i == 7 || m_cfg[i]) begin
          out_v[i] = run;
          run = 1'b1;
        end else begin
          out_v[i] = 1'b0;
        end
      end
      m_s1 <= pins; m_s2 <= m_s1; m_pv <= m_s2;
      m_st <= src_we ? 8'h00 : (m_st | set_v);
      m_match <= out_v;
      if (src_we) m_src <= src_wdata & 32'hFFFF_FF00;
      if (cfg_we) m_cfg <= cfg_wdata & 32'hFFFF_FF7F;
    end
  end

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    chk({24'h0, match_o}, {24'h0, m_match}, cur_tag);
    chk(src_q, m_src, "R2");
    chk(cfg_q, m_cfg, "R2");
  endtask

  task automatic wr_src(input logic [31:0] v);
    src_we = 1'b1; src_wdata = v;
    step();
    src_we = 1'b0;
  endtask

  task automatic wr_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] cv;
    void'($urandom(32'h5EED_0042));
    rst = 1'b1; pins = '0; src_we = 0; cfg_we = 0; src_wdata = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk({24'h0, match_o}, 32'h0, "R1");
    chk(src_q, 32'h0, "R1");
    chk(cfg_q, rst_cfg(), "R1");

    // R2 field masking
    cur_tag = "R2";
    wr_src(32'hFFFF_FFFF);
    chk(src_q, 32'hFFFF_FF00, "R2");
    wr_cfg(mk_cfg({8{3'd6}}, 7'h00) | 32'h0000_0080);
    chk(cfg_q[7], 1'b0, "R2");

    // R3 level high with latency
    cur_tag = "R3";
    wr_src(32'h0);
    cv = {8{3'd6}}; cv[2:0] = 3'd4;
    wr_cfg(mk_cfg(cv, 7'h01));
    repeat (4) step();
    pins[0] = 1'b1;
    step(); chk(match_o[0], 1'b0, "R3");
    step(); chk(match_o[0], 1'b0, "R3");
    step(); chk(match_o[0], 1'b1, "R3");
    cv[2:0] = 3'd5;
    wr_cfg(mk_cfg(cv, 7'h01));
    step(); chk(match_o[0], 1'b0, "R3");

    // R7 single-cycle event
    cur_tag = "R7";
    pins = '0;
    cv = {8{3'd6}}; cv[2:0] = 3'd7;
    wr_src(32'h0000_0100);
    wr_cfg(mk_cfg(cv, 7'h01));
    repeat (4) step();
    pins[1] = 1'b1;
    step(); step();
    step(); chk(match_o[0], 1'b1, "R7");
    step(); chk(match_o[0], 1'b0, "R7");

    // R4 always / never
    cur_tag = "R4";
    wr_cfg(mk_cfg({8{3'd0}}, 7'h7F));
    step(); chk({24'h0, match_o}, 32'hFF, "R4");
    cv = {8{3'd0}}; cv[11:9] = 3'd6;
    wr_cfg(mk_cfg(cv, 7'h7F));
    step(); chk({24'h0, match_o}, 32'hF7, "R4");

    // R5/R9 sticky rise on slice 7 closing a chain with no endpoint flags
    cur_tag = "R5";
    pins = '0;
    cv = {8{3'd0}}; cv[23:21] = 3'd1;
    wr_cfg(mk_cfg(cv, 7'h00));
    wr_src({3'd3, 29'h0});
    repeat (4) step();
    pins[3] = 1'b1; step(); pins[3] = 1'b0;
    repeat (6) step();
    chk({24'h0, match_o}, 32'h80, "R5");
    chk(match_o[7], 1'b1, "R9");

    // R6 rewrite same selection value clears sticky
    cur_tag = "R6";
    wr_src({3'd3, 29'h0});
    step(); chk(match_o[7], 1'b0, "R6");
    step(); chk(match_o[7], 1'b0, "R6");

    // R9 all always, no flags: only slice 7 reports
    cur_tag = "R9";
    wr_cfg(mk_cfg({8{3'd0}}, 7'h00));
    step(); chk({24'h0, match_o}, 32'h80, "R9");

    // R8 three-slice term ending at slice 2
    cur_tag = "R8";
    cv = {8{3'd6}}; cv[8:0] = {3'd4, 3'd4, 3'd4};
    wr_cfg(mk_cfg(cv, 7'h04));
    wr_src({15'h0, 3'd2, 3'd1, 3'd0, 8'h00});
    for (int p = 0; p < 8; p++) begin
      pins = 8'(p);
      repeat (4) step();
      chk({29'h0, match_o[2:0]}, {29'h0, (p == 7), 2'b00}, "R8");
    end

    // R10 random traffic against the model
    cur_tag = "R10";
    for (int n = 0; n < 3000; n++) begin
      pins = 8'($urandom);
      cfg_we = ($urandom % 12) == 0;
      cfg_wdata = $urandom;
      src_we = ($urandom % 20) == 0;
      src_wdata = $urandom;
      step();
    end
    cfg_we = 0; src_we = 0;
    repeat (4) step();
    finish_run();
  end

endmodule